// File: doc/BRIEF.md
# Conversion Start Trigger Selector

This block decides when a data converter begins a conversion. A select field picks one hardware event from a vector of trigger sources. A synchronizer and a rising-edge detector then watch that source. While auto-triggering is enabled and the converter is idle, an edge produces a one-cycle start pulse. On the same cycle it produces a one-cycle pulse that clears the converter's clock prescaler, so the delay from event to sample is always the same. A software start strobe launches a single conversion whether auto-triggering is on or off.

One select code is reserved for the converter's own completion event. With that code chosen, each completion immediately launches the next conversion. The converter then runs continuously, and the state of its interrupt flag has no bearing on this. The first conversion in that mode must come from software. Edges that arrive while the converter is busy are discarded. A source that is still high when a conversion finishes does not start another one. The converter's busy level, merged with a start in flight, is reported as an activity status. The converter's own timing is outside this block.

Top module: `trg_autostart`

## Requirements
- R1: While `rst_n` is low, `start_o` and `presc_rst_o` are 0.
- R2: With `auto_en` low, no source activity and no completion pulse produce `start_o` or `presc_rst_o`. Only `sw_start` can start a conversion.
- R3: With `auto_en` high and the converter idle, take a selected source that is first sampled high at clock edge n after being low at edge n-1. `start_o` and `presc_rst_o` are then both high for exactly the one cycle that follows edge n+SYNC_STAGES (edge n+2 with defaults).
- R4: A detected edge is discarded if `busy` is high, or if `start_o` is high, in the cycle the edge is detected. It does not produce a start later either.
- R5: A selected source that stays high across the completion of a conversion produces no further start.
- R6: With `trig_sel` equal to FLAG_SEL (default code 0) and `auto_en` high, a `conv_done` pulse in the cycle before edge m produces `start_o` and `presc_rst_o` in the cycle after edge m. This happens independently of any flag state.
- R7: In the completion-event mode, no conversion starts until software starts the first one.
- R8: `sw_start` sampled high at an edge while `busy` and `start_o` are low gives `start_o` in the following cycle, with `presc_rst_o` low. This holds with `auto_en` high or low. `sw_start` while busy is ignored.
- R9: `active_o` is high in every cycle in which `busy` or `start_o` is high, and low otherwise.
- R10: Select codes that map to no source slot (code 7 with defaults) act as a constant-low source and never trigger.
- R11: With FLAG_SEL = 0, select code k (1 to NSRC) watches `trig_src[k-1]` only. Activity on other sources is ignored.
- R12: `start_o` never stays high for two consecutive cycles, and `presc_rst_o` is high only together with `start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_src | input | NSRC | Hardware trigger source levels |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | SEL_W | Trigger source select code |
| sw_start | input | 1 | Software single-conversion start strobe |
| busy | input | 1 | Converter is converting |
| conv_done | input | 1 | One-cycle pulse at conversion completion |
| start_o | output | 1 | One-cycle conversion start pulse |
| presc_rst_o | output | 1 | One-cycle prescaler clear for hardware-started conversions |
| active_o | output | 1 | Conversion in flight (start issued or busy) |

## Verification
A source edge first appears at `start_o` SYNC_STAGES clocks after the edge at which it is sampled. A software strobe or a completion pulse appears one clock after its sampling edge. The bench's reference model keeps a history of the sampled selected-source level and reads it at those exact offsets. It samples inputs only at rising edges and compares outputs a short time after each edge, after every register has settled. A converter model answers each start by raising `busy` for a fixed number of cycles and then pulsing `conv_done`. Directed scenarios count pulses over windows that are longer than the total latency, and they also probe the exact cycle of the pulse after a source edge.

// File: rtl/trg_pkg.sv
package trg_pkg;
   // Maps a select code to an external source index, skipping the reserved code.
   function automatic int slot_to_src(input int slot, input int flag_code);
      return (slot < flag_code) ? slot : slot - 1;
   endfunction
endpackage

// File: rtl/trg_src_mux.sv
module trg_src_mux
   import trg_pkg::*;
#(
   parameter int NSRC     = 6,
   parameter int SEL_W    = 3,
   parameter int FLAG_SEL = 0
) (
   input  logic [NSRC-1:0]  trig_src,
   input  logic [SEL_W-1:0] trig_sel,
   output logic             sel_level,
   output logic             flag_mode
);
   localparam int SLOTS = 2 ** SEL_W;

   logic [SLOTS-1:0] slot_val;

   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_slot
         localparam int IDX = slot_to_src(g, FLAG_SEL);
         if (g == FLAG_SEL) begin : g_flag
            assign slot_val[g] = 1'b0;
         end else if (IDX < NSRC) begin : g_ext
            assign slot_val[g] = trig_src[IDX];
         end else begin : g_unused
            assign slot_val[g] = 1'b0;
         end
      end
   endgenerate

   assign sel_level = slot_val[trig_sel];
   assign flag_mode = (trig_sel == SEL_W'(FLAG_SEL));
endmodule

// File: rtl/trg_sync_edge.sv
module trg_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic synced;
   logic prev;

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= din;
         end
         assign synced = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[STAGES-2:0], din};
         end
         assign synced = q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= synced;
   end

   assign rise = synced & ~prev;
endmodule

// File: rtl/trg_start_ctl.sv
module trg_start_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic flag_mode,
   input  logic rise,
   input  logic conv_done,
   input  logic sw_start,
   input  logic busy,
   output logic start_o,
   output logic presc_rst_o
);
   logic hw_req;
   logic idle;

   assign hw_req = auto_en & (flag_mode ? conv_done : rise);
   assign idle   = ~busy & ~start_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o     <= 1'b0;
         presc_rst_o <= 1'b0;
      end else begin
         start_o     <= idle & (sw_start | hw_req);
         presc_rst_o <= idle & hw_req;
      end
   end
endmodule

// File: rtl/trg_autostart.sv
module trg_autostart #(
   parameter int NSRC        = 6,
   parameter int SEL_W       = 3,
   parameter int FLAG_SEL    = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  trig_src,
   input  logic             auto_en,
   input  logic [SEL_W-1:0] trig_sel,
   input  logic             sw_start,
   input  logic             busy,
   input  logic             conv_done,
   output logic             start_o,
   output logic             presc_rst_o,
   output logic             active_o
);
   localparam int SLOTS = 2 ** SEL_W;

   generate
      if (NSRC < 1 || NSRC > SLOTS - 1) begin : g_bad_nsrc
         $error("NSRC must fit in the select space beside the reserved code");
      end
      if (FLAG_SEL < 0 || FLAG_SEL >= SLOTS) begin : g_bad_flag
         $error("FLAG_SEL outside the select space");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic sel_level;
   logic flag_mode;
   logic rise;

   trg_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W), .FLAG_SEL(FLAG_SEL)) u_mux (
      .trig_src  (trig_src),
      .trig_sel  (trig_sel),
      .sel_level (sel_level),
      .flag_mode (flag_mode)
   );

   trg_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (sel_level),
      .rise  (rise)
   );

   trg_start_ctl u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_en     (auto_en),
      .flag_mode   (flag_mode),
      .rise        (rise),
      .conv_done   (conv_done),
      .sw_start    (sw_start),
      .busy        (busy),
      .start_o     (start_o),
      .presc_rst_o (presc_rst_o)
   );

   assign active_o = busy | start_o;
endmodule

// File: rtl/trg_autostart_chk.sv
module trg_autostart_chk (
   input logic clk,
   input logic rst_n,
   input logic auto_en,
   input logic sw_start,
   input logic busy,
   input logic start_o,
   input logic presc_rst_o
);
   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!start_o && !presc_rst_o); // R1
      end
   end

   AST_ONE_CYCLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o); // R12
   AST_PRESC_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
      presc_rst_o |-> start_o); // R12
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !start_o); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_en && !sw_start) |=> !start_o); // R2
   AST_SW_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_start && !busy && !start_o) |=> start_o); // R8
endmodule

bind trg_autostart trg_autostart_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .auto_en     (auto_en),
   .sw_start    (sw_start),
   .busy        (busy),
   .start_o     (start_o),
   .presc_rst_o (presc_rst_o)
);

// File: tb/sim_trg_autostart.sv
`timescale 1ns/1ps
module sim_trg_autostart;
   localparam int CONV = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] trig_src = '0;
   logic       auto_en = 1'b0;
   logic [2:0] trig_sel = '0;
   logic       sw_start = 1'b0;
   logic       busy = 1'b0;
   logic       conv_done = 1'b0;
   logic       start_o, presc_rst_o, active_o;

   int checks = 0;
   int errors = 0;
   int n_start = 0;
   int n_presc = 0;

   always #5 clk = ~clk;

   trg_autostart u0 (
      .clk(clk), .rst_n(rst_n), .trig_src(trig_src), .auto_en(auto_en),
      .trig_sel(trig_sel), .sw_start(sw_start), .busy(busy), .conv_done(conv_done),
      .start_o(start_o), .presc_rst_o(presc_rst_o), .active_o(active_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Converter model: busy for CONV cycles after each start, then a done pulse.
   int cnt = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         cnt = 0; busy = 1'b0; conv_done = 1'b0;
      end else begin
         conv_done = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin busy = 1'b0; conv_done = 1'b1; end
         end else if (start_o) begin
            cnt = CONV; busy = 1'b1;
         end
      end
   end

   // Behavioural reference: history of the sampled selected-source level.
   bit hist[$] = '{0, 0, 0, 0};
   bit exp_start = 0;
   bit exp_presc = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{0, 0, 0, 0}; exp_start = 0; exp_presc = 0;
      end else begin
         bit raw, edge_seen, idle, hw;
         int idx;
         idx = int'(trig_sel) - 1;
         raw = (trig_sel != 0 && idx < 6) ? trig_src[idx] : 1'b0;
         edge_seen = hist[$-1] && !hist[$-2];
         idle = !busy && !exp_start;
         hw = auto_en && ((trig_sel == 0) ? conv_done : edge_seen);
         exp_start = idle && (sw_start || hw);
         exp_presc = idle && hw;
         hist.push_back(raw);
         if (hist.size() > 8) void'(hist.pop_front());
      end
   end

   // Per-clock comparison, away from the active edge.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         chk(start_o == exp_start, "R3 R6 R8 start_o model", start_o, exp_start);
         chk(presc_rst_o == exp_presc, "R3 R6 presc_rst_o model", presc_rst_o, exp_presc);
         chk(active_o == (busy || exp_start), "R9 active_o model", active_o, busy || exp_start);
         if (start_o) n_start++;
         if (presc_rst_o) n_presc++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sw();
      @(negedge clk); sw_start = 1'b1;
      @(negedge clk); sw_start = 1'b0;
   endtask

   initial begin
      int s0, p0;
      cyc(3);
      chk(start_o == 0, "R1 start_o in reset", start_o, 0);
      chk(presc_rst_o == 0, "R1 presc_rst_o in reset", presc_rst_o, 0);
      rst_n = 1'b1;
      cyc(3);

      // R8: software start with auto off
      s0 = n_start; p0 = n_presc;
      pulse_sw();
      cyc(3);
      chk(active_o == 1, "R9 active during conversion", active_o, 1);
      cyc(CONV + 4);
      chk(n_start - s0 == 1, "R8 sw start count", n_start - s0, 1);
      chk(n_presc - p0 == 0, "R8 no prescaler clear", n_presc - p0, 0);
      chk(active_o == 0, "R9 inactive when idle", active_o, 0);

      // R2: auto off, source edges ignored
      s0 = n_start; trig_sel = 3'd3;
      cyc(1); trig_src = 6'h3F; cyc(4); trig_src = 6'h00; cyc(4); trig_src = 6'h3F; cyc(6);
      trig_src = 6'h00; cyc(4);
      chk(n_start == s0, "R2 auto off ignores edges", n_start - s0, 0);

      // R3: exact latency of a source edge
      auto_en = 1'b1; cyc(4);
      s0 = n_start; p0 = n_presc;
      trig_src[2] = 1'b1;
      cyc(2);
      chk(start_o == 0, "R3 no start before latency", start_o, 0);
      cyc(1);
      chk(start_o == 1, "R3 start at latency", start_o, 1);
      chk(presc_rst_o == 1, "R3 prescaler clear at latency", presc_rst_o, 1);
      // R4/R5: re-edge during busy, then held high through completion
      cyc(2); trig_src[2] = 1'b0; cyc(1); trig_src[2] = 1'b1;
      cyc(CONV + 12);
      chk(n_start - s0 == 1, "R4 R5 busy edge and held level ignored", n_start - s0, 1);
      chk(n_presc - p0 == 1, "R4 prescaler clear count", n_presc - p0, 1);
      trig_src[2] = 1'b0; cyc(4);

      // R11: other sources ignored, selected one used
      s0 = n_start;
      trig_src = 6'h3B; cyc(5); trig_src = 6'h00; cyc(5);
      chk(n_start == s0, "R11 unselected sources ignored", n_start - s0, 0);
      trig_sel = 3'd1; cyc(4);
      trig_src[0] = 1'b1; cyc(CONV + 6); trig_src[0] = 1'b0; cyc(3);
      chk(n_start - s0 == 1, "R11 code 1 watches source 0", n_start - s0, 1);

      // R10: unused select code
      s0 = n_start; trig_sel = 3'd7; cyc(3);
      trig_src = 6'h3F; cyc(5); trig_src = 6'h00; cyc(5); trig_src = 6'h3F; cyc(5);
      trig_src = 6'h00; cyc(3);
      chk(n_start == s0, "R10 unused code never triggers", n_start - s0, 0);

      // R7/R6: completion-event mode
      trig_sel = 3'd0; s0 = n_start; cyc(20);
      chk(n_start == s0, "R7 no start without software", n_start - s0, 0);
      p0 = n_presc;
      pulse_sw();
      cyc(5 * (CONV + 2));
      chk(n_start - s0 >= 4, "R6 continuous conversions", n_start - s0, 4);
      chk(n_presc - p0 == n_start - s0 - 1, "R6 prescaler clear per hw start",
          n_presc - p0, n_start - s0 - 1);
      auto_en = 1'b0; cyc(CONV + 4);
      s0 = n_start; cyc(30);
      chk(n_start == s0, "R2 free run stops when disabled", n_start - s0, 0);

      // R8: software start ignored while busy, also with auto on
      auto_en = 1'b1; trig_sel = 3'd5; cyc(3);
      s0 = n_start; p0 = n_presc;
      pulse_sw(); cyc(3); pulse_sw();
      cyc(CONV + 6);
      chk(n_start - s0 == 1, "R8 sw start while busy ignored", n_start - s0, 1);
      chk(n_presc - p0 == 0, "R8 sw start with auto on no clear", n_presc - p0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule